// File: doc/BRIEF.md
# Sectored Flash Program/Erase Engine

This block is a scaled, synthesizable model of a byte-wide NOR flash array and the engine that carries out its slow operations. A command decoder upstream hands it one request at a time: program a byte, erase one sector, erase the whole array, or set the boot lock. The engine maps the byte address onto seven sectors of unequal size, runs each operation for a fixed number of clock cycles with `busy` raised, and then leaves the array in the state that operation defines. A separate read port returns stored bytes at any time.

The seven-sector map is asymmetric: one boot sector of 1/16 of the array, two parameter sectors of 1/32 each, one main sector of 1/8 and three main sectors of 1/4. A parameter places the boot sector at the bottom or at the top of the address space. Once software sets the boot lock, the boot sector is shielded from program and erase, unless the high-voltage override input is asserted. The lock survives the functional reset and is cleared only by the power-on reset.

Top module: `flash_pe_engine`

## Requirements
- R1: The sector is chosen by the five top address bits t. With the boot sector at the bottom: t 0-1 boot, 2 parameter A, 3 parameter B, 4-7 main 1, 8-15 main 2, 16-23 main 3, 24-31 main 4. With it at the top: t 30-31 boot, 29 parameter A, 28 parameter B, 24-27 main 1, 16-23 main 2, 8-15 main 3, 0-7 main 4.
- R2: A sector erase (cmd_op 2'b01) sets every byte of the sector holding cmd_addr to 8'hFF and leaves every other byte unchanged.
- R3: A byte program (cmd_op 2'b00) stores the bitwise AND of the old byte and cmd_data, so bits can only go from 1 to 0.
- R4: An accepted program holds busy high for exactly PROG_CYCLES cycles and an accepted erase for exactly ERASE_CYCLES cycles; after reset busy, reject and boot_locked are low.
- R5: A lock command (cmd_op 2'b11) raises boot_locked on the next edge without raising busy; boot_locked is unaffected by rst_n and is cleared only by por_n.
- R6: While boot_locked is high and hv_override is low, a program or sector erase addressing the boot sector is refused: reject pulses for one cycle, busy stays low and the array is unchanged; other sectors are still accepted.
- R7: A chip erase (cmd_op 2'b10) sets the whole array to 8'hFF when unlocked, and every sector except the boot sector when locked.
- R8: With hv_override high, boot sector program, sector erase and chip erase proceed even while boot_locked is high.
- R9: rst_n low at a clock edge ends any operation in progress: busy is low after that edge and a byte program that had not completed leaves its byte unchanged.
- R10: A command presented while busy is high is ignored: no reject, no change to the array, no change to the running operation.
- R11: rd_data shows the byte at rd_addr one clock edge after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears the boot lock |
| rst_n | input | 1 | Functional reset, active low, synchronous; aborts operations |
| hv_override | input | 1 | High-voltage condition; lifts boot sector protection |
| cmd_valid | input | 1 | Request strobe, taken when busy is low |
| cmd_op | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 set lock |
| cmd_addr | input | AW | Byte address, also selects the sector to erase |
| cmd_data | input | 8 | Byte to program |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Operation in progress |
| reject | output | 1 | One-cycle pulse for a refused protected request |
| boot_locked | output | 1 | Boot lock state |

## Verification
The two functions that can land on one clock edge are the completion of a byte program, which writes the array, and the functional reset, which must abort it. The bench counts the program's cycles and drops rst_n so that it is low at exactly the edge on which the timer expires, then reads the byte back and expects the erased value and an idle busy. A second overlap, a new request arriving while a chip erase sweeps the array, is provoked mid-erase and judged by the absence of a reject and by the untouched target byte afterwards.

// File: rtl/flash_pe_engine.sv
module flash_pe_engine #(
  parameter int AW           = 10,
  parameter bit TOP_BOOT     = 1'b0,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 2048   // must cover 2**AW sweep cycles
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          hv_override,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          reject,
  output logic          boot_locked
);

  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [1:0] {OP_PROG = 2'b00, OP_SERASE = 2'b01,
                            OP_CERASE = 2'b10, OP_LOCK = 2'b11} op_t;

  function automatic logic [2:0] sector_of(input logic [AW-1:0] a);
    logic [4:0] t;
    t = a[AW-1 -: 5];
    if (!TOP_BOOT) begin
      if (t < 5'd2)        return 3'd0;
      else if (t == 5'd2)  return 3'd1;
      else if (t == 5'd3)  return 3'd2;
      else if (t < 5'd8)   return 3'd3;
      else if (t < 5'd16)  return 3'd4;
      else if (t < 5'd24)  return 3'd5;
      else                 return 3'd6;
    end else begin
      if (t >= 5'd30)      return 3'd0;
      else if (t == 5'd29) return 3'd1;
      else if (t == 5'd28) return 3'd2;
      else if (t >= 5'd24) return 3'd3;
      else if (t >= 5'd16) return 3'd4;
      else if (t >= 5'd8)  return 3'd5;
      else                 return 3'd6;
    end
  endfunction

  logic [7:0]    mem [DEPTH];
  op_t           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    sec_q;
  logic          skip_boot_q;
  logic [CW-1:0] cnt;
  logic [AW:0]   ptr;

  op_t  req_op;
  logic take, guarded, boot_hit, erase_op, sweep_hit;

  assign req_op    = op_t'(cmd_op);
  assign take      = cmd_valid && !busy;
  assign boot_hit  = sector_of(cmd_addr) == 3'd0;
  assign guarded   = boot_locked && !hv_override && boot_hit &&
                     (req_op == OP_PROG || req_op == OP_SERASE);
  assign erase_op  = op_q == OP_SERASE || op_q == OP_CERASE;
  assign sweep_hit = (op_q == OP_SERASE) ? (sector_of(ptr[AW-1:0]) == sec_q)
                   : !(skip_boot_q && sector_of(ptr[AW-1:0]) == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      reject <= 1'b0;
      cnt    <= '0;
      ptr    <= '0;
    end else begin
      reject <= 1'b0;
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
        if (!ptr[AW])  ptr  <= ptr + 1'b1;
      end else if (cmd_valid && req_op != OP_LOCK) begin
        if (guarded) begin
          reject <= 1'b1;
        end else begin
          busy <= 1'b1;
          ptr  <= '0;
          cnt  <= (req_op == OP_PROG) ? CW'(PROG_CYCLES - 1) : CW'(ERASE_CYCLES - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && take && !guarded) begin
      op_q        <= req_op;
      addr_q      <= cmd_addr;
      data_q      <= cmd_data;
      sec_q       <= sector_of(cmd_addr);
      skip_boot_q <= boot_locked && !hv_override;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)
      boot_locked <= 1'b0;
    else if (rst_n && take && req_op == OP_LOCK)
      boot_locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_n && busy) begin
      if (op_q == OP_PROG && cnt == '0)
        mem[addr_q] <= mem[addr_q] & data_q;
      if (erase_op && !ptr[AW] && sweep_hit)
        mem[ptr[AW-1:0]] <= 8'hFF;
    end
    rd_data <= mem[rd_addr];
  end

  // R6: a refused request never coincides with a running operation
  p_reject_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy);

  // R6: a reject pulse always follows a presented request
  p_reject_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> $past(cmd_valid));

  // R4: busy only rises in answer to a request
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R5: the lock never falls while power-on reset is released
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    boot_locked |=> boot_locked);

  // R9: functional reset ends every operation
  p_abort_r9: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !busy);

  // R10: requests during an operation never produce a reject
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !reject);

endmodule

// File: tb/flash_pe_engine_tb.sv
module flash_pe_engine_tb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int PC = 6;
  localparam int EC = 1030;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, rst_n = 1'b0, hv = 1'b0;
  logic cv = 1'b0, cv2 = 1'b0;
  logic [1:0] cop = '0, cop2 = '0;
  logic [AW-1:0] cad = '0, cad2 = '0, rad = '0;
  logic [7:0] cdt = '0, cdt2 = '0;
  logic [7:0] rdt, rdt2;
  logic bsy, rej, lck, bsy2, rej2, lck2;

  flash_pe_engine #(.AW(AW), .TOP_BOOT(1'b0), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .hv_override(hv),
    .cmd_valid(cv), .cmd_op(cop), .cmd_addr(cad), .cmd_data(cdt),
    .rd_addr(rad), .rd_data(rdt), .busy(bsy), .reject(rej), .boot_locked(lck));

  flash_pe_engine #(.AW(AW), .TOP_BOOT(1'b1), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut_top (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .hv_override(1'b0),
    .cmd_valid(cv2), .cmd_op(cop2), .cmd_addr(cad2), .cmd_data(cdt2),
    .rd_addr(rad), .rd_data(rdt2), .busy(bsy2), .reject(rej2), .boot_locked(lck2));

  int tests = 0, fails = 0;
  logic [7:0] model [DEPTH];

  typedef struct { logic [7:0] exp; int addr; string tag; } item_t;
  item_t sbq[$];
  logic rd_fire = 1'b0, mon_go = 1'b0;

  always @(posedge clk) mon_go <= rd_fire;

  always @(negedge clk) begin
    if (mon_go && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      tests++;
      if (rdt !== it.exp) begin
        fails++;
        $display("FAIL %s read @%0d: got %h expected %h", it.tag, it.addr, rdt, it.exp);
      end
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = model[a]; it.addr = a; it.tag = tag;
    sbq.push_back(it);
    rad = AW'(a); rd_fire = 1'b1;
    @(negedge clk);
    rd_fire = 1'b0;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    cv = 1'b1; cop = op; cad = AW'(a); cdt = d;
    @(negedge clk);
    cv = 1'b0;
  endtask

  task automatic cmd2(input logic [1:0] op, input int a);
    @(negedge clk);
    cv2 = 1'b1; cop2 = op; cad2 = AW'(a); cdt2 = 8'h00;
    @(negedge clk);
    cv2 = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (bsy) begin n++; @(negedge clk); end
  endtask

  task automatic model_fill(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) model[i] = 8'hFF;
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    int n;
    cmd(2'b00, a, d);
    busy_len(n);
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check(bsy, 0, "R4 busy after reset");
    check(rej, 0, "R4 reject after reset");
    check(lck, 0, "R5 lock after power-on");

    // R7 unlocked chip erase, R4 erase duration
    cmd(2'b10, 0, 8'h00);
    busy_len(n);
    check(n, EC, "R4 erase busy length");
    model_fill(0, DEPTH-1);
    rd_chk(0, "R7 boot erased");
    rd_chk(DEPTH-1, "R7 top erased");

    // R3 program and R4 program duration
    cmd(2'b00, 256, 8'hA5);
    busy_len(n);
    check(n, PC, "R4 program busy length");
    model[256] = 8'hA5;
    rd_chk(256, "R3 first program");
    prog(256, 8'h3C);
    rd_chk(256, "R3 and with old");
    prog(256, 8'hFF);
    rd_chk(256, "R3 cannot set bits");

    // R1 / R2 sector boundaries, bottom boot
    prog(63, 8'h00); prog(64, 8'h11); prog(95, 8'h22);
    prog(96, 8'h33); prog(127, 8'h44); prog(128, 8'h55);
    cmd(2'b01, 80, 8'h00);
    busy_len(n);
    model_fill(64, 95);
    rd_chk(63, "R1 boot end kept");
    rd_chk(64, "R2 param A start erased");
    rd_chk(95, "R2 param A end erased");
    rd_chk(96, "R1 param B kept");
    cmd(2'b01, 127, 8'h00);
    busy_len(n);
    model_fill(96, 127);
    rd_chk(96, "R2 param B erased");
    rd_chk(128, "R1 main 1 kept");
    rd_chk(256, "R2 main 2 untouched");

    // R5 lock, R6 protection
    cmd(2'b11, 0, 8'h00);
    check(lck, 1, "R5 lock set");
    check(bsy, 0, "R5 lock no busy");
    cmd(2'b00, 10, 8'h00);
    check(rej, 1, "R6 program boot rejected");
    check(bsy, 0, "R6 busy stays low");
    @(negedge clk);
    check(rej, 0, "R6 reject one cycle");
    rd_chk(10, "R6 boot byte unchanged");
    cmd(2'b01, 63, 8'h00);
    check(rej, 1, "R6 erase boot rejected");
    rd_chk(63, "R6 boot kept after refused erase");
    cmd(2'b00, 200, 8'h0F);
    check(rej, 0, "R6 main sector accepted");
    busy_len(n);
    model[200] = model[200] & 8'h0F;
    rd_chk(200, "R6 main sector programmed");

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(lck, 1, "R5 lock survives rst_n");

    // R7 locked chip erase, R10 ignore while busy
    cmd(2'b10, 0, 8'h00);
    repeat (100) @(negedge clk);
    cmd(2'b00, 300, 8'h00);
    check(rej, 0, "R10 no reject while busy");
    cmd(2'b00, 5, 8'h00);
    check(rej, 0, "R10 no reject on boot while busy");
    busy_len(n);
    model_fill(64, DEPTH-1);
    rd_chk(63, "R7 boot kept when locked");
    rd_chk(200, "R7 main erased");
    rd_chk(300, "R10 ignored program absent");
    rd_chk(5, "R10 ignored boot program absent");

    // R8 override
    hv = 1'b1;
    cmd(2'b00, 5, 8'h5A);
    check(rej, 0, "R8 override accepts boot program");
    busy_len(n);
    model[5] = 8'h5A;
    hv = 1'b0;
    rd_chk(5, "R8 boot programmed under override");
    hv = 1'b1;
    cmd(2'b10, 0, 8'h00);
    hv = 1'b0;
    busy_len(n);
    model_fill(0, DEPTH-1);
    rd_chk(63, "R8 chip erase clears boot under override");

    // R9 reset at the completing edge
    cmd(2'b00, 400, 8'h0F);
    repeat (PC-1) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(bsy, 0, "R9 busy dropped");
    rst_n = 1'b1;
    rd_chk(400, "R9 aborted program left byte");

    // R11 registered read
    @(negedge clk);
    rad = AW'(5);
    @(negedge clk);
    rad = AW'(6);
    #1;
    check(rdt, 8'hFF, "R11 data of previous address");

    // R1 top-boot map
    cmd2(2'b11, 0);
    check(lck2, 1, "R5 top instance lock");
    cmd2(2'b00, DEPTH-1);
    check(rej2, 1, "R1 top boot at highest address");
    cmd2(2'b00, 960);
    check(rej2, 1, "R1 top boot start");
    cmd2(2'b00, 959);
    check(rej2, 0, "R1 top param A below boot");
    while (bsy2) @(negedge clk);
    cmd2(2'b00, 0);
    check(rej2, 0, "R1 top low address is main");
    while (bsy2) @(negedge clk);

    // R5 power-on reset clears lock
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    check(lck, 0, "R5 lock cleared by por_n");
    cmd(2'b00, 10, 8'hF0);
    check(rej, 0, "R5 boot writable after por_n");
    busy_len(n);

    repeat (4) @(negedge clk);
    check(sbq.size(), 0, "scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule